// File: doc/BRIEF.md
# Three-Phase Dead-Time Inserter

This block sits between a motor-control timer and six gate-driver pins. For each of the three phases U, V and W, it receives two request lines from upstream: one for the high-side switch and one for the low-side switch. It drives two active-low gate outputs per phase. When a request line rises, the output it asks for is held off for a programmable dead time. This gives the opposite switch of the same leg time to turn off before the new one turns on. When a request line falls, its output goes inactive on the next clock.

Each phase has its own 8-bit one-shot down-counter. All three counters take their start value from one shared reload register. A rising edge on either request of a phase reloads that phase's counter, even if a count is already running. The counter then decrements on every clock, or on every second clock, and stops at zero.

A master enable drives all six outputs. Software can clear it, and a falling edge on the active-low `nmi_n` input also clears it. When the enable is clear, every pair is released: its outputs are inactive and its drive flag is low. An optional shoot-through guard releases any single pair whose two outputs would both be active in the same cycle.

Top module: `dtins_top`

## Requirements
- R1: After reset, all six gate outputs are high, every `pair_drive` bit is 0, the master enable, the guard and the slow count source are off, and the dead-time reload value is 1.
- R2: A write with `wr_addr`=0 loads `wr_data` into the shared dead-time reload register. A write of 0 to that address is ignored, and the register keeps its previous nonzero value.
- R3: With the fast count source (control bit 2 = 0), a rising request keeps its output high for exactly N clocks, where N is the reload value. The output goes low on the (N+1)th clock after the request is sampled.
- R4: When a request is sampled low, its output is high from the very next clock, with no dead time.
- R5: A rising edge on either request of a phase while that phase is counting reloads the counter. The full dead time starts again from that edge.
- R6: With control bit 2 = 1, the counter decrements only every second clock. The dead time is then 2N-1 or 2N clocks.
- R7: A write with `wr_addr`=1 loads the control bits: bit 0 is the master enable, bit 1 is the guard enable and bit 2 is the count-source select. While the enable is 0, all outputs are high and `pair_drive` is 0.
- R8: The enable is cleared on the third clock after `nmi_n` goes from high to low. The input passes through a two-stage synchronizer before edge detection.
- R9: With the guard on, a phase whose two outputs would both be low is released instead: both outputs are high and its `pair_drive` bit is 0. Other phases are not affected. With the guard off, both outputs of that phase go low.
- R10: The three phases count independently of one another, although they share one reload value.
- R11: An NMI-triggered clear takes priority over a control write that sets the enable in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the dead-time reload register, 1 selects the control register |
| wr_data | input | 8 | Write data |
| up_req | input | 3 | High-side requests; bit 0 is U, bit 1 is V, bit 2 is W |
| dn_req | input | 3 | Low-side requests, with the same bit order as `up_req` |
| nmi_n | input | 1 | Asynchronous shutdown input; a falling edge clears the enable |
| gate_p_n | output | 3 | Active-low high-side gate drives |
| gate_n_n | output | 3 | Active-low low-side gate drives |
| pair_drive | output | 3 | 1 means the pair is driven; 0 means it is released to its port default |

## Verification
The assertions assume that the reload value is never zero. Because of this, a request that has just risen must still leave its output high on the next clock. The stimulus writes 0 only to check that such a write is ignored. The NMI check assumes that `nmi_n` stays low for at least three clocks, so that the synchronized edge is seen. The stimulus always holds it low for longer than that. All requests change half a clock away from the active edge, so every edge the counters see is a clean single-cycle transition.

// File: rtl/dtins_pkg.sv
package dtins_pkg;
    localparam int PHASES = 3;

    typedef struct packed {
        logic div2;
        logic guard_en;
        logic out_en;
    } ctl_t;
endpackage

// File: rtl/dtins_regs.sv
module dtins_regs
    import dtins_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int RESET_DT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             nmi_n,
    output logic [CNT_W-1:0] reload,
    output ctl_t             ctl,
    output logic             nmi_fall
);
    typedef struct packed {
        logic [CNT_W-1:0] reload;
        ctl_t             ctl;
        logic [2:0]       nmi_sync;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.nmi_sync = {st_q.nmi_sync[1:0], nmi_n};
        nmi_fall      = st_q.nmi_sync[2] & ~st_q.nmi_sync[1];
        if (wr_en) begin
            if (!wr_addr) begin
                if (wr_data != '0) st_d.reload = wr_data;
            end else begin
                st_d.ctl = ctl_t'(wr_data[2:0]);
            end
        end
        if (nmi_fall) st_d.ctl.out_en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.reload   <= CNT_W'(RESET_DT);
            st_q.ctl      <= '0;
            st_q.nmi_sync <= 3'b111;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload = st_q.reload;
    assign ctl    = st_q.ctl;
endmodule

// File: rtl/dtins_tick.sv
module dtins_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic div2,
    output logic tick
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = ~tog_q;
        tick  = div2 ? tog_q : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end
endmodule

// File: rtl/dtins_phase.sv
module dtins_phase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    input  logic             up_req,
    input  logic             dn_req,
    input  logic             out_en,
    input  logic             guard_en,
    output logic             gate_p_n,
    output logic             gate_n_n,
    output logic             drive
);
    typedef struct packed {
        logic             up;
        logic             dn;
        logic [CNT_W-1:0] cnt;
    } ph_t;

    ph_t  ph_d, ph_q;
    logic trig, pos_on, neg_on, trip;

    always_comb begin
        ph_d    = ph_q;
        ph_d.up = up_req;
        ph_d.dn = dn_req;
        trig    = (up_req & ~ph_q.up) | (dn_req & ~ph_q.dn);
        if (trig)                           ph_d.cnt = reload;
        else if (tick && ph_q.cnt != '0)    ph_d.cnt = ph_q.cnt - 1'b1;

        pos_on   = ph_q.up & (ph_q.cnt == '0);
        neg_on   = ph_q.dn & (ph_q.cnt == '0);
        trip     = guard_en & pos_on & neg_on;
        drive    = out_en & ~trip;
        gate_p_n = ~(drive & pos_on);
        gate_n_n = ~(drive & neg_on);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/dtins_top.sv
module dtins_top
    import dtins_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int RESET_DT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [PHASES-1:0] up_req,
    input  logic [PHASES-1:0] dn_req,
    input  logic              nmi_n,
    output logic [PHASES-1:0] gate_p_n,
    output logic [PHASES-1:0] gate_n_n,
    output logic [PHASES-1:0] pair_drive
);
    ctl_t             ctl;
    logic [CNT_W-1:0] reload_val;
    logic             nmi_fall;
    logic             tick;
    logic             out_en_w, guard_en_w;

    dtins_regs #(.CNT_W(CNT_W), .RESET_DT(RESET_DT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .nmi_n(nmi_n), .reload(reload_val),
        .ctl(ctl), .nmi_fall(nmi_fall)
    );

    assign out_en_w   = ctl.out_en;
    assign guard_en_w = ctl.guard_en;

    dtins_tick u_tick (.clk(clk), .rst_n(rst_n), .div2(ctl.div2), .tick(tick));

    for (genvar i = 0; i < PHASES; i++) begin : g_phase
        dtins_phase #(.CNT_W(CNT_W)) u_phase (
            .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload_val),
            .up_req(up_req[i]), .dn_req(dn_req[i]),
            .out_en(out_en_w), .guard_en(guard_en_w),
            .gate_p_n(gate_p_n[i]), .gate_n_n(gate_n_n[i]),
            .drive(pair_drive[i])
        );
    end
endmodule

// File: rtl/dtins_chk.sv
module dtins_chk
    import dtins_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PHASES-1:0] up_req,
    input logic [PHASES-1:0] dn_req,
    input logic [PHASES-1:0] gate_p_n,
    input logic [PHASES-1:0] gate_n_n,
    input logic [PHASES-1:0] pair_drive,
    input logic              nmi_fall,
    input logic              out_en,
    input logic              guard_en,
    input logic [CNT_W-1:0]  reload
);
    AST_RELOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) reload != '0); // R2
    AST_DISABLED_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !out_en |-> pair_drive == '0); // R7
    AST_NMI_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n) nmi_fall |=> pair_drive == '0); // R8

    for (genvar i = 0; i < PHASES; i++) begin : g_chk
        AST_UP_ON_DELAY: assert property (@(posedge clk) disable iff (!rst_n) $rose(up_req[i]) |=> gate_p_n[i]); // R3
        AST_DN_ON_DELAY: assert property (@(posedge clk) disable iff (!rst_n) $rose(dn_req[i]) |=> gate_n_n[i]); // R3
        AST_UP_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_n) !up_req[i] |=> gate_p_n[i]); // R4
        AST_DN_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_n) !dn_req[i] |=> gate_n_n[i]); // R4
        AST_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !pair_drive[i] |-> (gate_p_n[i] && gate_n_n[i])); // R7
        AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) guard_en |-> (gate_p_n[i] || gate_n_n[i])); // R9
    end
endmodule

bind dtins_top dtins_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .dn_req(dn_req),
    .gate_p_n(gate_p_n), .gate_n_n(gate_n_n), .pair_drive(pair_drive),
    .nmi_fall(nmi_fall), .out_en(out_en_w), .guard_en(guard_en_w),
    .reload(reload_val)
);

// File: tb/dtins_top_test.sv
module dtins_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] up_req = '0;
    logic [2:0] dn_req = '0;
    logic       nmi_n = 1'b1;
    logic [2:0] gate_p_n, gate_n_n, pair_drive;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dtins_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .up_req(up_req), .dn_req(dn_req), .nmi_n(nmi_n),
        .gate_p_n(gate_p_n), .gate_n_n(gate_n_n), .pair_drive(pair_drive)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    function automatic logic gate(input int ph, input bit pos);
        return pos ? gate_p_n[ph] : gate_n_n[ph];
    endfunction

    task automatic rise_and_time(input int ph, input bit pos, input int n, input string req);
        if (pos) up_req[ph] = 1'b1; else dn_req[ph] = 1'b1;
        step(n);
        chk({req, " still dead"}, {31'd0, gate(ph, pos)}, 32'd1);
        step(1);
        chk({req, " on after dead time"}, {31'd0, gate(ph, pos)}, 32'd0);
    endtask

    task automatic idle_all();
        up_req = '0; dn_req = '0;
        step(2);
    endtask

    task automatic t_reset();
        chk("R1 gate_p_n", {29'd0, gate_p_n}, 32'h7);
        chk("R1 gate_n_n", {29'd0, gate_n_n}, 32'h7);
        chk("R1 pair_drive", {29'd0, pair_drive}, 32'h0);
        wr(1'b1, 8'h01);
        rise_and_time(0, 1'b1, 1, "R1 reset reload 1");
        idle_all();
    endtask

    task automatic t_dead_time();
        wr(1'b0, 8'd5);
        rise_and_time(1, 1'b0, 5, "R3 N=5");
        idle_all();
        wr(1'b0, 8'd3);
        wr(1'b0, 8'd0);
        rise_and_time(2, 1'b1, 3, "R2 zero write ignored");
        idle_all();
    endtask

    task automatic t_turn_off();
        wr(1'b0, 8'd4);
        up_req[0] = 1'b1;
        step(6);
        up_req[0] = 1'b0; dn_req[0] = 1'b1;
        step(1);
        chk("R4 high side off at once", {31'd0, gate_p_n[0]}, 32'd1);
        chk("R4 low side held dead", {31'd0, gate_n_n[0]}, 32'd1);
        step(3);
        chk("R3 low side still dead", {31'd0, gate_n_n[0]}, 32'd1);
        step(1);
        chk("R3 low side on", {31'd0, gate_n_n[0]}, 32'd0);
        dn_req[0] = 1'b0;
        step(1);
        chk("R4 low side off at once", {31'd0, gate_n_n[0]}, 32'd1);
        idle_all();
    endtask

    task automatic t_retrigger();
        wr(1'b0, 8'd5);
        up_req[1] = 1'b1;
        step(3);
        up_req[1] = 1'b0;
        step(1);
        up_req[1] = 1'b1;
        step(5);
        chk("R5 retrigger restarts dead time", {31'd0, gate_p_n[1]}, 32'd1);
        step(1);
        chk("R5 on after restarted dead time", {31'd0, gate_p_n[1]}, 32'd0);
        idle_all();
    endtask

    task automatic t_div2();
        wr(1'b0, 8'd4);
        wr(1'b1, 8'h05);
        up_req[2] = 1'b1;
        step(6);
        chk("R6 slow source still dead", {31'd0, gate_p_n[2]}, 32'd1);
        step(3);
        chk("R6 slow source on by 2N", {31'd0, gate_p_n[2]}, 32'd0);
        wr(1'b1, 8'h01);
        idle_all();
    endtask

    task automatic t_independent();
        wr(1'b0, 8'd4);
        up_req[0] = 1'b1;
        step(2);
        dn_req[1] = 1'b1;
        step(3);
        chk("R10 U on", {31'd0, gate_p_n[0]}, 32'd0);
        chk("R10 V still dead", {31'd0, gate_n_n[1]}, 32'd1);
        step(2);
        chk("R10 V on", {31'd0, gate_n_n[1]}, 32'd0);
        idle_all();
    endtask

    task automatic t_guard();
        wr(1'b0, 8'd2);
        wr(1'b1, 8'h03);
        up_req[2] = 1'b1; dn_req[2] = 1'b1;
        step(3);
        chk("R9 guard releases W", {29'd0, pair_drive}, 32'h3);
        chk("R9 W outputs high", {30'd0, gate_p_n[2], gate_n_n[2]}, 32'h3);
        wr(1'b1, 8'h01);
        chk("R9 guard off both low", {30'd0, gate_p_n[2], gate_n_n[2]}, 32'h0);
        chk("R9 guard off drives W", {29'd0, pair_drive}, 32'h7);
        idle_all();
    endtask

    task automatic t_enable();
        wr(1'b0, 8'd1);
        up_req[1] = 1'b1;
        step(3);
        chk("R7 enabled output low", {31'd0, gate_p_n[1]}, 32'd0);
        wr(1'b1, 8'h00);
        chk("R7 disabled outputs high", {26'd0, gate_p_n, gate_n_n}, 32'h3f);
        chk("R7 disabled released", {29'd0, pair_drive}, 32'h0);
        wr(1'b1, 8'h01);
        chk("R7 re-enabled output low", {31'd0, gate_p_n[1]}, 32'd0);
        idle_all();
    endtask

    task automatic t_nmi();
        nmi_n = 1'b0;
        step(2);
        chk("R8 still driven before sync", {29'd0, pair_drive}, 32'h7);
        step(1);
        chk("R8 NMI clears enable", {29'd0, pair_drive}, 32'h0);
        step(2);
        nmi_n = 1'b1;
        step(4);
        wr(1'b1, 8'h01);
        chk("R8 software re-enable", {29'd0, pair_drive}, 32'h7);
        nmi_n = 1'b0;
        step(2);
        wr(1'b1, 8'h01);
        chk("R11 NMI beats write", {29'd0, pair_drive}, 32'h0);
        step(2);
        nmi_n = 1'b1;
        step(4);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_dead_time();
        t_turn_off();
        t_retrigger();
        t_div2();
        t_independent();
        t_guard();
        t_enable();
        t_nmi();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule